// File: doc/BRIEF.md
# Phased PWM Output Controller

This block drives five power-switch gate requests from one free-running 7-bit period counter. A host writes one control word per channel over a simple address/data write port. Each word either forces the channel low, runs it as a pulse-width modulated output with 1/128 resolution, or holds it continuously high. Every channel also picks a quarter-period offset for the start of its on-window, so the five loads can be spread across the period instead of all switching together.

New control words are staged and only become active at the period boundary, so a pulse never gets cut short or stretched partway through. The block also keeps one flag per channel that tells the protection logic to skip the high over-current limit. The host sets these flags through a configuration word. They clear themselves when a channel is switched off, when that channel reports an over-temperature or over-current fault, and all together on an under-voltage fault.

Top module: `phpwm_ctrl`

## Requirements
- R1: The control word of channel n (n = 1..5) is written at address 0x09 + (n-1), i.e. 0x09..0x0D. A write to any other address except 0x03 leaves every channel output unchanged.
- R2: The shared period counter is 0 in reset. It increments on every clock and wraps from 127 to 0. The cycle in which it reads 0 is the period boundary.
- R3: A control word with bit 7 (enable) at 0 keeps the channel output low in every cycle, whatever duty code is in bits 6:0.
- R4: With enable at 1, the output is high for exactly code+1 cycles of each 128-cycle period, where code is the 7-bit duty field in bits 6:0.
- R5: With enable at 1 and duty code 0x7F, the output stays high in every cycle of the period.
- R6: Bits 9:8 select the start count of the on-window: 00 gives 0, 11 gives 32, 01 gives 64 and 10 gives 96. At count c the output is high when ((c - start) mod 128) <= code, so a window may wrap past count 127.
- R7: A control word that has been written takes effect at the next period boundary. The period in progress keeps the old settings to its end.
- R8: A write to address 0x03 loads the five high-limit-disable flags from data bits 4:0, bit i belonging to channel i+1. The flags are visible on the next cycle.
- R9: An over-temperature or over-current fault on a channel clears that channel's flag on the next cycle. This wins over a configuration write in the same cycle.
- R10: An under-voltage fault clears all five flags on the next cycle.
- R11: When a channel's active enable goes from 1 to 0 at a period boundary, its flag is cleared at that same boundary. Before the boundary the flag keeps its value.
- R12: In reset all outputs are low and all flags are clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one period-counter step per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 10 | Write data: bits 9:8 phase, bit 7 enable, bits 6:0 duty |
| ot_fault | input | 5 | Per-channel over-temperature fault |
| oc_fault | input | 5 | Per-channel over-current fault |
| uv_fault | input | 1 | Under-voltage fault shared by all channels |
| ch_out | output | 5 | Channel output requests |
| no_hi_limit | output | 5 | Per-channel flag: high over-current limit disabled |

## Verification
The checker assumes that fault inputs and write strobes are synchronous to the clock and have settled before each rising edge. It also assumes that the outputs are unregistered, the default variant, for the checks that relate active settings to the output in the same cycle. The bench drives every input on the falling edge and holds each write or fault pulse for exactly one rising edge. It never asserts a fault and a clear-triggering channel write on the same edge except in the one case that tests that priority. Expected waveforms come from a bench-side count of rising edges since reset, not from the design's counter.

// File: rtl/phpwm_pkg.sv
package phpwm_pkg;

   // Phase-select encoding carried in the two bits above the enable bit.
   typedef enum logic [1:0] {
      PH_DEG0   = 2'b00,
      PH_DEG180 = 2'b01,
      PH_DEG270 = 2'b10,
      PH_DEG90  = 2'b11
   } phase_sel_e;

   // Number of quarter periods the on-window is delayed by.
   function automatic logic [1:0] phase_quarters(input phase_sel_e sel);
      logic [1:0] q;
      case (sel)
         PH_DEG0:   q = 2'd0;
         PH_DEG90:  q = 2'd1;
         PH_DEG180: q = 2'd2;
         PH_DEG270: q = 2'd3;
         default:   q = 2'd0;
      endcase
      return q;
   endfunction

endpackage

// File: rtl/phpwm_period_ctr.sv
module phpwm_period_ctr #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   assign cnt  = cnt_q;
   // High in the last count of a period; the next edge is the boundary.
   assign wrap = (cnt_q == CNT_MAX);
endmodule

// File: rtl/phpwm_channel.sv
module phpwm_channel
   import phpwm_pkg::*;
#(
   parameter int                CNT_W   = 7,
   parameter int                ADDR_W  = 5,
   parameter logic [ADDR_W-1:0] MY_ADDR = '0,
   parameter bit                OUT_REG = 1'b0,
   localparam int               CTRL_W  = CNT_W + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CTRL_W-1:0] wr_ctrl,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              wrap,
   output logic              pwm_out,
   output logic              act_en_o,
   output logic [CNT_W-1:0]  act_duty_o,
   output logic [1:0]        act_ph_o,
   output logic              en_fall
);
   localparam int QTR_W = CNT_W - 2;

   // Staged copy written by the host.
   logic             pend_en;
   logic [CNT_W-1:0] pend_duty;
   phase_sel_e       pend_ph;
   // Copy in use for the current period.
   logic             act_en;
   logic [CNT_W-1:0] act_duty;
   phase_sel_e       act_ph;

   logic             sel_me;
   logic [CNT_W-1:0] start_cnt;
   logic [CNT_W-1:0] rel_cnt;
   logic             hit;

   assign sel_me = wr_en && (wr_addr == MY_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_en   <= 1'b0;
         pend_duty <= '0;
         pend_ph   <= PH_DEG0;
      end else if (sel_me) begin
         pend_duty <= wr_ctrl[CNT_W-1:0];
         pend_en   <= wr_ctrl[CNT_W];
         pend_ph   <= phase_sel_e'(wr_ctrl[CNT_W+2:CNT_W+1]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_en   <= 1'b0;
         act_duty <= '0;
         act_ph   <= PH_DEG0;
      end else if (wrap) begin
         act_en   <= pend_en;
         act_duty <= pend_duty;
         act_ph   <= pend_ph;
      end
   end

   assign en_fall   = wrap && act_en && !pend_en;
   assign start_cnt = {phase_quarters(act_ph), {QTR_W{1'b0}}};
   assign rel_cnt   = cnt - start_cnt;
   // The top duty code covers every count, so it yields a steady high.
   assign hit       = act_en && (rel_cnt <= act_duty);

   generate
      if (OUT_REG) begin : g_out_reg
         logic out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= 1'b0;
            else        out_q <= hit;
         end
         assign pwm_out = out_q;
      end else begin : g_out_comb
         assign pwm_out = hit;
      end
   endgenerate

   assign act_en_o   = act_en;
   assign act_duty_o = act_duty;
   assign act_ph_o   = act_ph;
endmodule

// File: rtl/phpwm_guard_flags.sv
module phpwm_guard_flags #(
   parameter int                N_CH     = 5,
   parameter int                ADDR_W   = 5,
   parameter logic [ADDR_W-1:0] CFG_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [N_CH-1:0]   wr_bits,
   input  logic [N_CH-1:0]   ot_fault,
   input  logic [N_CH-1:0]   oc_fault,
   input  logic              uv_fault,
   input  logic [N_CH-1:0]   en_fall,
   output logic [N_CH-1:0]   flags
);
   logic [N_CH-1:0] flags_q;
   logic [N_CH-1:0] clr;
   logic [N_CH-1:0] loaded;

   assign clr    = ot_fault | oc_fault | en_fall | {N_CH{uv_fault}};
   assign loaded = (wr_en && (wr_addr == CFG_ADDR)) ? wr_bits : flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= loaded & ~clr;
   end

   assign flags = flags_q;
endmodule

// File: rtl/phpwm_ctrl.sv
module phpwm_ctrl #(
   parameter int  N_CH      = 5,
   parameter int  CNT_W     = 7,
   parameter int  ADDR_W    = 5,
   parameter int  CTRL_BASE = 9,
   parameter int  CFG_ADDR  = 3,
   parameter bit  OUT_REG   = 1'b0,
   localparam int DATA_W    = CNT_W + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [N_CH-1:0]   ot_fault,
   input  logic [N_CH-1:0]   oc_fault,
   input  logic              uv_fault,
   output logic [N_CH-1:0]   ch_out,
   output logic [N_CH-1:0]   no_hi_limit
);
   localparam int ADDR_SPAN = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_ADDR);

   generate
      if (CNT_W < 3) begin : g_chk_cnt
         $error("phpwm_ctrl: CNT_W must be at least 3");
      end
      if (N_CH < 1 || N_CH > DATA_W) begin : g_chk_nch
         $error("phpwm_ctrl: N_CH must be in 1..DATA_W");
      end
      if (CTRL_BASE + N_CH > ADDR_SPAN) begin : g_chk_span
         $error("phpwm_ctrl: channel addresses exceed address space");
      end
      if (CFG_ADDR >= CTRL_BASE && CFG_ADDR < CTRL_BASE + N_CH) begin : g_chk_cfg
         $error("phpwm_ctrl: configuration address overlaps channels");
      end
   endgenerate

   logic [CNT_W-1:0]      cnt;
   logic                  wrap;
   logic [N_CH-1:0]       act_en;
   logic [N_CH*CNT_W-1:0] act_duty_flat;
   logic [N_CH*2-1:0]     act_ph_flat;
   logic [N_CH-1:0]       en_fall;

   phpwm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk  (clk),
      .rst_n(rst_n),
      .cnt  (cnt),
      .wrap (wrap)
   );

   generate
      for (genvar i = 0; i < N_CH; i++) begin : g_ch
         phpwm_channel #(
            .CNT_W  (CNT_W),
            .ADDR_W (ADDR_W),
            .MY_ADDR(ADDR_W'(CTRL_BASE + i)),
            .OUT_REG(OUT_REG)
         ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en),
            .wr_addr   (wr_addr),
            .wr_ctrl   (wr_data),
            .cnt       (cnt),
            .wrap      (wrap),
            .pwm_out   (ch_out[i]),
            .act_en_o  (act_en[i]),
            .act_duty_o(act_duty_flat[i*CNT_W +: CNT_W]),
            .act_ph_o  (act_ph_flat[i*2 +: 2]),
            .en_fall   (en_fall[i])
         );
      end
   endgenerate

   phpwm_guard_flags #(
      .N_CH    (N_CH),
      .ADDR_W  (ADDR_W),
      .CFG_ADDR(CFG_A)
   ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_bits (wr_data[N_CH-1:0]),
      .ot_fault(ot_fault),
      .oc_fault(oc_fault),
      .uv_fault(uv_fault),
      .en_fall (en_fall),
      .flags   (no_hi_limit)
   );
endmodule

// File: rtl/phpwm_ctrl_chk.sv
module phpwm_ctrl_chk #(
   parameter int N_CH    = 5,
   parameter int CNT_W   = 7,
   parameter bit OUT_REG = 1'b0
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [CNT_W-1:0]      cnt,
   input logic                  wrap,
   input logic [N_CH-1:0]       act_en,
   input logic [N_CH*CNT_W-1:0] act_duty_flat,
   input logic [N_CH*2-1:0]     act_ph_flat,
   input logic [N_CH-1:0]       ch_out,
   input logic [N_CH-1:0]       ot_fault,
   input logic [N_CH-1:0]       oc_fault,
   input logic                  uv_fault,
   input logic [N_CH-1:0]       no_hi_limit
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_MAX) |=> (cnt == '0));

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable({act_en, act_duty_flat, act_ph_flat}));

   assert_uv_R10: assert property (@(posedge clk) disable iff (!rst_n)
      uv_fault |=> (no_hi_limit == '0));

   generate
      for (genvar i = 0; i < N_CH; i++) begin : g_prop
         assert_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (ot_fault[i] || oc_fault[i]) |=> !no_hi_limit[i]);

         if (!OUT_REG) begin : g_comb
            assert_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
               !act_en[i] |-> !ch_out[i]);

            assert_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
               (act_en[i] && act_duty_flat[i*CNT_W +: CNT_W] == CNT_MAX) |-> ch_out[i]);
         end
      end
   endgenerate
endmodule

bind phpwm_ctrl phpwm_ctrl_chk #(
   .N_CH   (N_CH),
   .CNT_W  (CNT_W),
   .OUT_REG(OUT_REG)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cnt          (cnt),
   .wrap         (wrap),
   .act_en       (act_en),
   .act_duty_flat(act_duty_flat),
   .act_ph_flat  (act_ph_flat),
   .ch_out       (ch_out),
   .ot_fault     (ot_fault),
   .oc_fault     (oc_fault),
   .uv_fault     (uv_fault),
   .no_hi_limit  (no_hi_limit)
);

// File: tb/phpwm_ctrl_tb.sv
`timescale 1ns/1ps
module phpwm_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [4:0] wr_addr = '0;
   logic [9:0] wr_data = '0;
   logic [4:0] ot_fault = '0;
   logic [4:0] oc_fault = '0;
   logic       uv_fault = 1'b0;
   logic [4:0] ch_out;
   logic [4:0] no_hi_limit;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   // Bench-side count of edges since reset (R2): period position = edges mod 128.
   int edges;
   // Expected active settings per channel.
   bit       s_en[5];
   int       s_code[5];
   int       s_ph[5];
   int       hi_cnt[5];

   always #2 clk = ~clk;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) edges <= 0;
      else        edges <= edges + 1;
   end

   phpwm_ctrl u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .ot_fault   (ot_fault),
      .oc_fault   (oc_fault),
      .uv_fault   (uv_fault),
      .ch_out     (ch_out),
      .no_hi_limit(no_hi_limit)
   );

   function automatic int pos();
      return edges % 128;
   endfunction

   function automatic logic [9:0] ctrl(input bit en, input int ph, input int code);
      return {ph[1:0], en, code[6:0]};
   endfunction

   function automatic bit exp_on(input int ch, input int c);
      int start;
      start = (s_ph[ch] == 0) ? 0 : (s_ph[ch] == 1) ? 64 : (s_ph[ch] == 2) ? 96 : 32;
      return s_en[ch] && (((c - start + 128) % 128) <= s_code[ch]);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
      end
   endtask

   task automatic reg_write(input int addr, input logic [9:0] data);
      wr_en   = 1'b1;
      wr_addr = addr[4:0];
      wr_data = data;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic wait_boundary();
      do @(negedge clk); while (pos() != 0);
   endtask

   task automatic set_shadow(input int ch, input bit en, input int ph, input int code);
      s_en[ch] = en; s_ph[ch] = ph; s_code[ch] = code;
   endtask

   // Compares all channels for one full period starting at position 0.
   task automatic scan_period(input string req);
      int mism = 0;
      logic [4:0] first_act = '0, first_exp = '0;
      for (int ch = 0; ch < 5; ch++) hi_cnt[ch] = 0;
      for (int k = 0; k < 128; k++) begin
         logic [4:0] e;
         for (int ch = 0; ch < 5; ch++) begin
            e[ch] = exp_on(ch, pos());
            if (ch_out[ch]) hi_cnt[ch]++;
         end
         if (e !== ch_out && mism == 0) begin
            first_act = ch_out; first_exp = e;
         end
         if (e !== ch_out) mism++;
         @(negedge clk);
      end
      check(mism == 0, req, first_act, first_exp);
   endtask

   task automatic t_reset();
      check(ch_out == 5'b0, "R12 outputs in reset", ch_out, 0);
      check(no_hi_limit == 5'b0, "R12 flags in reset", no_hi_limit, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(ch_out == 5'b0, "R12 outputs after reset", ch_out, 0);
   endtask

   task automatic t_duty_phase();
      reg_write(9,  ctrl(1, 0, 8'h00));
      reg_write(10, ctrl(1, 1, 8'h1A));
      reg_write(11, ctrl(1, 2, 8'h7F));
      reg_write(12, ctrl(1, 3, 8'h40));
      reg_write(13, ctrl(1, 2, 100));
      wait_boundary();
      set_shadow(0, 1, 0, 0);
      set_shadow(1, 1, 1, 8'h1A);
      set_shadow(2, 1, 2, 8'h7F);
      set_shadow(3, 1, 3, 8'h40);
      set_shadow(4, 1, 2, 100);
      scan_period("R6 phase windows (incl. wrap past 127)");
      check(hi_cnt[0] == 1,   "R4 code 0x00 width",  hi_cnt[0], 1);
      check(hi_cnt[1] == 27,  "R4 code 0x1A width",  hi_cnt[1], 27);
      check(hi_cnt[2] == 128, "R5 code 0x7F steady", hi_cnt[2], 128);
      check(hi_cnt[3] == 65,  "R4 code 0x40 width",  hi_cnt[3], 65);
      check(hi_cnt[4] == 101, "R4 code 100 wrapped width", hi_cnt[4], 101);
   endtask

   task automatic t_off();
      reg_write(10, ctrl(0, 1, 8'h55));
      wait_boundary();
      set_shadow(1, 0, 1, 8'h55);
      scan_period("R3 disabled channel");
      check(hi_cnt[1] == 0, "R3 disabled channel high count", hi_cnt[1], 0);
   endtask

   task automatic t_addr();
      reg_write(14, 10'h3FF);
      reg_write(8,  10'h000);
      reg_write(31, 10'h000);
      wait_boundary();
      scan_period("R1 stray addresses ignored");
   endtask

   task automatic t_midwrite();
      int mism = 0;
      wait_boundary();
      for (int k = 0; k < 128; k++) begin
         if (ch_out[3] !== exp_on(3, pos())) mism++;
         if (k == 40) begin
            wr_en = 1'b1; wr_addr = 5'd12; wr_data = ctrl(1, 0, 8'h10);
         end else begin
            wr_en = 1'b0;
         end
         @(negedge clk);
      end
      wr_en = 1'b0;
      check(mism == 0, "R7 period in progress keeps old settings", mism, 0);
      set_shadow(3, 1, 0, 8'h10);
      scan_period("R7 new settings from boundary");
      check(hi_cnt[3] == 17, "R7 new width", hi_cnt[3], 17);
   endtask

   task automatic t_flags();
      reg_write(3, 10'h01F);
      check(no_hi_limit == 5'h1F, "R8 config write", no_hi_limit, 5'h1F);
      oc_fault = 5'b00010;
      @(negedge clk);
      oc_fault = '0;
      check(no_hi_limit == 5'h1D, "R9 over-current clear", no_hi_limit, 5'h1D);
      ot_fault = 5'b01000;
      reg_write(3, 10'h01F);
      ot_fault = '0;
      check(no_hi_limit == 5'h17, "R9 fault beats write", no_hi_limit, 5'h17);
      uv_fault = 1'b1;
      @(negedge clk);
      uv_fault = 1'b0;
      check(no_hi_limit == 5'h00, "R10 under-voltage clears all", no_hi_limit, 0);
      reg_write(3, 10'h01F);
      // Channel 1 is active-enabled; turn it off.
      reg_write(9, ctrl(0, 0, 0));
      check(no_hi_limit == 5'h1F, "R11 flag kept before boundary", no_hi_limit, 5'h1F);
      wait_boundary();
      check(no_hi_limit == 5'h1E, "R11 flag cleared at boundary", no_hi_limit, 5'h1E);
   endtask

   initial begin
      #10;
      @(negedge clk);
      t_reset();
      t_duty_phase();
      t_off();
      t_addr();
      t_midwrite();
      t_flags();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule